// File: doc/BRIEF.md
# Eight-Channel Paddle Position Scanner

The block measures the settings of eight paddle controls. Each one drives an external RC network whose comparator output reaches this block as a single digital line. That line goes high once the capacitor has charged past the threshold. A strobe on `start_wr` launches a measurement. First the block holds `dump_caps` high for a short discharge window. Then a shared step counter runs upward from zero. On the first cycle a channel's comparator line is seen high, the counter value is captured into that channel's 8-bit result, and the channel's bit in the live status byte drops to zero. A channel that never crosses is given the full-scale count when the counter reaches its limit, and the scan then stops.

There are two pacing modes, and the mode is fixed when the scan is launched. In the accurate mode the counter steps once per scan-line tick, so a full sweep lasts one frame of 228 lines. In the quick mode it steps on every system clock, so the whole sweep fits in about two line times with coarser resolution. Results stay readable and unchanged until the next launch.

Top module: `paddle_scan`

## Requirements
- R1: After reset every result byte is 0, `scan_busy` is 8'h00 and `dump_caps` is 0.
- R2: A `start_wr` pulse sampled at a clock edge clears all results to 0 and sets `scan_busy` to 8'hFF at that edge. `dump_caps` is then 1 for exactly 2 cycles, beginning right after that edge. This also holds when the pulse arrives in the middle of a scan, which is restarted.
- R3: While `dump_caps` is 1, the comparator inputs are ignored: `scan_busy` stays 8'hFF even when inputs are high.
- R4: Quick mode (`fast_sel`=1 when launched): the counter is 0 on the first clock after the discharge window and steps by one on every clock. A channel captures the count of the first clock on which its input is high.
- R5: Accurate mode (`fast_sel`=0 when launched): the counter steps by one on each clock where `line_tick` is 1 after the discharge window. The captured value equals the number of ticks seen before the crossing.
- R6: Channel i's result occupies `paddle_values[8*i+7:8*i]`, and its status is `scan_busy[i]` (1 = still measuring).
- R7: When the counter reaches 228, every channel not yet crossed captures 228, `scan_busy` becomes 8'h00, and the scan ends.
- R8: Once captured, a result does not change for any input or tick activity until the next `start_wr`.
- R9: The pacing mode is sampled at launch. Changing `fast_sel` during a scan has no effect on that scan.
- R10: An input that is already high when the discharge window ends captures 0.
- R11: Only the first crossing counts. An input that falls and rises again later in the scan leaves the captured value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_wr | input | 1 | Start-register write strobe, one clock wide |
| fast_sel | input | 1 | Pacing select sampled at launch: 1 quick, 0 accurate |
| line_tick | input | 1 | One-clock pulse per scan line |
| pot_in | input | 8 | Comparator outputs, bit i for channel i |
| paddle_values | output | 64 | Eight captured counts, channel i at bits 8i+7..8i |
| scan_busy | output | 8 | Live per-channel measuring flags |
| dump_caps | output | 1 | Capacitor discharge control |

## Verification
The bench places crossings at chosen counts in both pacing modes. These include count 0, count 227, exactly 228 and beyond full scale, so an off-by-one in the step or capture timing shows as a result that is one count wrong, and a missing clamp shows as a wrong value on late channels. It holds all inputs high through the discharge window. A design that listens during the dump would clear status bits early. It bounces inputs and toggles activity after the scan, so a design that re-captures would overwrite results. It flips the mode bit mid-scan and also restarts a scan halfway. A design that reads the mode live would stall the counter, and one that mishandles a restart would leave stale values or status behind.

// File: rtl/paddle_scan_pkg.sv
package paddle_scan_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_DUMP    = 2'd1,
    PH_MEASURE = 2'd2
  } scan_phase_e;
endpackage

// File: rtl/paddle_scan_rstsync.sv
module paddle_scan_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/paddle_scan_pace.sv
// Step generator: one step per line tick, or one per FAST_DIV clocks.
module paddle_scan_pace #(
  parameter int FAST_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic measure,
  input  logic fast_q,
  input  logic line_tick,
  output logic step
);
  localparam int DIV_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FAST_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             fast_hit;

  assign fast_hit = (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    if (start)                div_d = '0;
    else if (measure && fast_q)
      div_d = fast_hit ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign step = measure & (fast_q ? fast_hit : line_tick);

  // R5: accurate mode never steps without a line tick
  assert_tick_paced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fast_q) |-> line_tick);
endmodule

// File: rtl/paddle_scan_ctrl.sv
// Scan sequencer: discharge window, shared counter, full-scale stop.
module paddle_scan_ctrl
  import paddle_scan_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FULL_COUNT = 228,
  parameter int DUMP_LEN   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fast_sel,
  input  logic             step,
  output logic             measure,
  output logic             dumping,
  output logic             finish,
  output logic             fast_q,
  output logic [CNT_W-1:0] count
);
  localparam int              DL_W     = $clog2(DUMP_LEN + 1);
  localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(FULL_COUNT);
  localparam logic [DL_W-1:0]  DUMP_VAL = DL_W'(DUMP_LEN);

  scan_phase_e      phase_q, phase_d;
  logic [DL_W-1:0]  dump_q, dump_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             fast_d;

  always_comb begin
    phase_d = phase_q;
    dump_d  = dump_q;
    count_d = count_q;
    fast_d  = fast_q;
    if (start) begin
      phase_d = PH_DUMP;
      dump_d  = DUMP_VAL;
      count_d = '0;
      fast_d  = fast_sel;
    end else begin
      unique case (phase_q)
        PH_DUMP: begin
          dump_d = dump_q - 1'b1;
          if (dump_q == DL_W'(1)) phase_d = PH_MEASURE;
        end
        PH_MEASURE: begin
          if (count_q == FULL_VAL) phase_d = PH_IDLE;
          else if (step)           count_d = count_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dump_q  <= '0;
      count_q <= '0;
      fast_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dump_q  <= dump_d;
      count_q <= count_d;
      fast_q  <= fast_d;
    end
  end

  assign count   = count_q;
  assign measure = (phase_q == PH_MEASURE);
  assign dumping = (phase_q == PH_DUMP);
  assign finish  = measure && (count_q == FULL_VAL);

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_VAL);
  assert_start_dumps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dumping && count_q == '0));
  assert_finish_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !start) |=> (!measure && !dumping));
  assert_count_waits_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (measure && !step && !start && !finish) |=> $stable(count_q));
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(fast_q));
endmodule

// File: rtl/paddle_scan_lane.sv
// One channel: capture register and busy flag.
module paddle_scan_lane #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             measure,
  input  logic             dumping,
  input  logic             finish,
  input  logic [CNT_W-1:0] count,
  input  logic             pot,
  output logic [CNT_W-1:0] value,
  output logic             busy
);
  logic [CNT_W-1:0] value_q, value_d;
  logic             busy_q, busy_d;
  logic             capture;

  assign capture = busy_q && measure && (pot || finish);

  always_comb begin
    value_d = value_q;
    busy_d  = busy_q;
    if (start) begin
      value_d = '0;
      busy_d  = 1'b1;
    end else if (capture) begin
      value_d = count;
      busy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      value_q <= value_d;
      busy_q  <= busy_d;
    end
  end

  assign value = value_q;
  assign busy  = busy_q;

  assert_capture_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (value_q == $past(count)));
  assert_dump_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dumping && busy_q && !start) |=> busy_q);
  assert_value_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(value_q));
endmodule

// File: rtl/paddle_scan.sv
module paddle_scan #(
  parameter int NUM_CH     = 8,
  parameter int CNT_W      = 8,
  parameter int FULL_COUNT = 228,
  parameter int DUMP_LEN   = 2,
  parameter int FAST_DIV   = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_wr,
  input  logic                    fast_sel,
  input  logic                    line_tick,
  input  logic [NUM_CH-1:0]       pot_in,
  output logic [NUM_CH*CNT_W-1:0] paddle_values,
  output logic [NUM_CH-1:0]       scan_busy,
  output logic                    dump_caps
);
  logic             rst_n_sync;
  logic             measure, dumping, finish, fast_q, step;
  logic [CNT_W-1:0] count;

  paddle_scan_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  paddle_scan_ctrl #(
    .CNT_W      (CNT_W),
    .FULL_COUNT (FULL_COUNT),
    .DUMP_LEN   (DUMP_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .start    (start_wr),
    .fast_sel (fast_sel),
    .step     (step),
    .measure  (measure),
    .dumping  (dumping),
    .finish   (finish),
    .fast_q   (fast_q),
    .count    (count)
  );

  paddle_scan_pace #(
    .FAST_DIV (FAST_DIV)
  ) u_pace (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start     (start_wr),
    .measure   (measure),
    .fast_q    (fast_q),
    .line_tick (line_tick),
    .step      (step)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    paddle_scan_lane #(
      .CNT_W (CNT_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .start   (start_wr),
      .measure (measure),
      .dumping (dumping),
      .finish  (finish),
      .count   (count),
      .pot     (pot_in[ch]),
      .value   (paddle_values[ch*CNT_W +: CNT_W]),
      .busy    (scan_busy[ch])
    );
  end

  assign dump_caps = dumping;

  assert_finish_clears_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (finish && !start_wr) |=> (scan_busy == '0));
  assert_start_all_busy_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    start_wr |=> (scan_busy == '1 && paddle_values == '0));
endmodule

// File: tb/sim_paddle_scan.sv
module sim_paddle_scan;
  localparam int NCH  = 8;
  localparam int LP   = 3;
  localparam int FULL = 228;

  logic             clk = 1'b0;
  logic             rst_n, start_wr, fast_sel, line_tick;
  logic [NCH-1:0]   pot_in;
  logic [NCH*8-1:0] paddle_values;
  logic [NCH-1:0]   scan_busy;
  logic             dump_caps;

  int             n_tests = 0;
  int             n_fail  = 0;
  int             tgt[NCH];
  logic [NCH-1:0] bounce;
  bit             done = 1'b0;

  always #5 clk = ~clk;

  paddle_scan u0 (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .fast_sel(fast_sel),
    .line_tick(line_tick), .pot_in(pot_in), .paddle_values(paddle_values),
    .scan_busy(scan_busy), .dump_caps(dump_caps)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] val(input int i);
    return paddle_values[8*i +: 8];
  endfunction

  task automatic begin_scan(input bit fast, input logic [NCH-1:0] pre);
    @(negedge clk);
    pot_in = pre; fast_sel = fast; start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    chk("R2 dump high after start", dump_caps, 1);
    chk("R2 status all busy", scan_busy, 8'hFF);
    chk("R2 results cleared", (paddle_values == '0), 1);
    @(negedge clk);
    chk("R3 status held during dump", scan_busy, 8'hFF);
    chk("R2 dump second cycle", dump_caps, 1);
    @(negedge clk);
    chk("R2 dump released", dump_caps, 0);
  endtask

  task automatic run_iters(input bit fast, input int from, input int upto);
    for (int k = from; k <= upto; k++) begin
      for (int i = 0; i < NCH; i++)
        pot_in[i] = bounce[i] ? ((k == tgt[i]) || (k >= tgt[i] + 10)) : (k >= tgt[i]);
      if (fast) @(negedge clk);
      else begin
        for (int c = 0; c < LP; c++) begin
          line_tick = (c == LP - 1);
          @(negedge clk);
        end
        line_tick = 1'b0;
      end
      if (k == 100) begin
        logic [NCH-1:0] eb;
        for (int i = 0; i < NCH; i++) eb[i] = (tgt[i] > 100);
        chk("R6 live status mid-scan", scan_busy, eb);
      end
    end
  endtask

  task automatic check_results(input string req);
    for (int i = 0; i < NCH; i++)
      chk(req, val(i), (tgt[i] > FULL) ? FULL : tgt[i]);
    chk("R7 status clear at end", scan_busy, 8'h00);
    chk("R7 dump low at end", dump_caps, 0);
  endtask

  task automatic full_scan(input bit fast, input logic [NCH-1:0] pre, input string req);
    begin_scan(fast, pre);
    run_iters(fast, 0, FULL);
    repeat (2) @(negedge clk);
    check_results(req);
  endtask

  task automatic t_reset;
    chk("R1 results zero", (paddle_values == '0), 1);
    chk("R1 status zero", scan_busy, 0);
    chk("R1 dump low", dump_caps, 0);
  endtask

  task automatic t_fast;
    tgt = '{0, 1, 5, 57, 100, 200, 227, 250};
    bounce = '0;
    full_scan(1'b1, '0, "R4 R6 R7 quick capture");
  endtask

  task automatic t_normal;
    tgt = '{3, 0, 228, 10, 99, 150, 101, 300};
    bounce = '0;
    full_scan(1'b0, '0, "R5 R6 R7 accurate capture");
  endtask

  task automatic t_dump_ignore;
    tgt = '{0, 0, 0, 0, 0, 0, 0, 0};
    bounce = '0;
    full_scan(1'b1, 8'hFF, "R10 R3 high through dump captures 0");
  endtask

  task automatic t_bounce;
    tgt = '{20, 40, 60, 80, 20, 40, 60, 80};
    bounce = 8'h0F;
    full_scan(1'b1, '0, "R11 first crossing only");
    bounce = '0;
  endtask

  task automatic t_mode_flip;
    tgt = '{7, 14, 33, 90, 128, 180, 226, 240};
    bounce = '0;
    begin_scan(1'b1, '0);
    fast_sel = 1'b0;
    run_iters(1'b1, 0, FULL);
    repeat (2) @(negedge clk);
    check_results("R9 mode latched at launch");
  endtask

  task automatic t_hold;
    logic [NCH*8-1:0] snap;
    snap = paddle_values;
    for (int c = 0; c < 30; c++) begin
      pot_in = NCH'(c * 37);
      line_tick = c[0];
      @(negedge clk);
    end
    line_tick = 1'b0;
    chk("R8 results held after scan", (paddle_values == snap), 1);
    chk("R8 status stays idle", scan_busy, 8'h00);
  endtask

  task automatic t_restart;
    tgt = '{2, 30, 45, 90, 120, 160, 210, 229};
    bounce = '0;
    begin_scan(1'b1, '0);
    run_iters(1'b1, 0, 60);
    chk("R2 partial capture before restart", val(2), 45);
    begin_scan(1'b0, '0);
    run_iters(1'b0, 0, FULL);
    repeat (2) @(negedge clk);
    check_results("R2 R5 scan after restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_wr = 1'b0; fast_sel = 1'b0; line_tick = 1'b0;
    pot_in = '0; bounce = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fast();
    t_hold();
    t_normal();
    t_dump_ignore();
    t_bounce();
    t_mode_flip();
    t_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule